// File: doc/BRIEF.md
# SR Phase Current Balancer

This block balances the load current carried by two interleaved resonant phases. It does this by trimming the synchronous-rectifier conduction time of one phase, while the conduction time of the other phase is held constant. Shortening a rectifier's on-time raises the resistance of that phase's secondary path, so that phase carries less current and the other phase carries more. The block acts only on a control tick that the surrounding logic raises for one clock every six PWM periods. Between ticks, every output holds its value.

The controller moves through four phases of operation: idle, arming, a joint ramp and regulation. It waits in idle until the output voltage and the total load current are both high enough. On the arming tick it compares the filtered phase currents once, and the phase with the smaller current becomes the fixed phase. Both rectifiers then switch on at the minimum on-time and ramp together up to a ceiling derived from the half-period. After the ramp, the other phase is trimmed up or down by a small step on each tick until the currents are equal. When the load current drops below a lower threshold, the rectifiers switch off and the controller returns to idle. The gap between the turn-on and turn-off current thresholds gives hysteresis.

All times are counts of 250 ps. A downstream edge generator places each falling edge 50 ns before the end of its half-period and subtracts the on-time to find the rising edge. Growing the on-time therefore moves only the rising edge earlier.

Top module: `sr_phase_balancer`

## Requirements
- R1: After reset, state_o is 0 (idle), both enables are 0 and both on-times are 400 (100 ns).
- R2: In idle, a tick moves state_o to 1 (arming) only when vout_i > VOUT_ON (600) and itot_i > IOUT_ON (140). On any other tick the block stays in idle, with the enables at 0 and the on-times at 400.
- R3: On the arming tick, phase B becomes the fixed phase if ib_i < ia_i. Otherwise phase A becomes the fixed phase. This includes a tie. The choice holds until the block returns to idle.
- R4: The arming tick moves state_o to 2 (ramp), sets both enables to 1 and sets both on-times to 400.
- R5: On each ramp tick, both on-times rise by 40 (10 ns). When the new value would reach or pass the ceiling, both on-times take the ceiling and state_o becomes 3 (regulate). The ceiling is half_per_i − 496 (124 ns), with a floor of 400.
- R6: On a regulate tick, the on-time of the adjusted phase falls by 8 (2 ns) if that phase's current is greater than the fixed phase's current. It rises by 8 if that phase's current is smaller.
- R7: On a regulate tick with equal currents, the adjusted on-time is unchanged. The fixed phase's on-time never changes while the block is regulating.
- R8: During regulation, a step down never takes the on-time below 400, and a step up never takes it above the ceiling.
- R9: A tick in the ramp or regulate state with itot_i < IOUT_OFF (100) sends the block to idle. Both enables go to 0 and both on-times go to 400.
- R10: While tick_i is low, state_o, the enables and the on-times hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Control tick, one clock every six PWM periods |
| ia_i | input | 12 | Filtered phase A current |
| ib_i | input | 12 | Filtered phase B current |
| itot_i | input | 12 | Total output current |
| vout_i | input | 12 | Output voltage |
| half_per_i | input | 16 | PWM half-period in 250 ps counts |
| sr_en_a_o | output | 1 | Phase A rectifier enable |
| sr_en_b_o | output | 1 | Phase B rectifier enable |
| ton_a_o | output | 16 | Phase A rectifier on-time, 250 ps counts |
| ton_b_o | output | 16 | Phase B rectifier on-time, 250 ps counts |
| state_o | output | 2 | 0 idle, 1 arming, 2 ramp, 3 regulate |

## Verification
Two functions can fall on the same tick: the current drop-out and either a ramp step or a trim step. The tick that would finish the ramp is one such case. The bench provokes these collisions by driving itot_i below 100 on ramp and regulate ticks, both in directed cases and in random traffic. A correct result is a return to idle with the rectifiers off and the on-times at 400, with no ramp or trim applied on that tick. Clamping at the ceiling and ending the ramp also fall on the same tick. This case is judged against a reference model running in the bench, including the case where the ceiling equals the floor.

// File: rtl/sr_bal_pkg.sv
package sr_bal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RAMP = 2'd2,
    ST_RUN  = 2'd3
  } bal_state_e;

  typedef enum logic [2:0] {
    TC_HOLD = 3'd0,
    TC_MIN  = 3'd1,
    TC_RAMP = 3'd2,
    TC_UP   = 3'd3,
    TC_DOWN = 3'd4
  } trim_cmd_e;
endpackage

// File: rtl/sr_bal_limit.sv
module sr_bal_limit #(
  parameter int W     = 16,
  parameter int MIN_T = 400,
  parameter int OFF_T = 496
) (
  input  logic [W-1:0] half_per_i,
  output logic [W-1:0] max_o
);
  localparam logic [W:0] BOUND = (W+1)'(MIN_T + OFF_T);
  localparam logic [W-1:0] MINV = W'(MIN_T);
  localparam logic [W-1:0] OFFV = W'(OFF_T);

  always_comb begin
    if ({1'b0, half_per_i} > BOUND) max_o = half_per_i - OFFV;
    else                             max_o = MINV;
  end
endmodule

// File: rtl/sr_bal_trim.sv
module sr_bal_trim
  import sr_bal_pkg::*;
#(
  parameter int W      = 16,
  parameter int MIN_T  = 400,
  parameter int RAMP_T = 40,
  parameter int TRIM_T = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  trim_cmd_e    cmd_i,
  input  logic [W-1:0] max_i,
  output logic [W-1:0] ton_o,
  output logic         ramp_full_o
);
  localparam logic [W:0]   RAMPX = (W+1)'(RAMP_T);
  localparam logic [W:0]   TRIMX = (W+1)'(TRIM_T);
  localparam logic [W-1:0] MINV  = W'(MIN_T);
  localparam logic [W-1:0] TRIMV = W'(TRIM_T);
  localparam logic [W:0]   DNLIM = (W+1)'(MIN_T + TRIM_T);

  logic [W-1:0] ton_q, ton_d;
  logic [W:0]   sum_ramp, sum_up;

  assign sum_ramp    = {1'b0, ton_q} + RAMPX;
  assign sum_up      = {1'b0, ton_q} + TRIMX;
  assign ramp_full_o = sum_ramp >= {1'b0, max_i};

  always_comb begin
    ton_d = ton_q;
    unique case (cmd_i)
      TC_MIN:  ton_d = MINV;
      TC_RAMP: ton_d = ramp_full_o ? max_i : sum_ramp[W-1:0];
      TC_UP:   ton_d = (sum_up > {1'b0, max_i}) ? max_i : sum_up[W-1:0];
      TC_DOWN: ton_d = ({1'b0, ton_q} < DNLIM) ? MINV : ton_q - TRIMV;
      default: ton_d = ton_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ton_q <= MINV;
    else         ton_q <= ton_d;
  end

  assign ton_o = ton_q;

  a_r8_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ton_q >= MINV);

  a_r6_step_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == TC_UP || cmd_i == TC_DOWN) |=>
      ((ton_q >= $past(ton_q)) ? (ton_q - $past(ton_q)) : ($past(ton_q) - ton_q)) <= TRIMV);

  a_r10_hold_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == TC_HOLD |=> $stable(ton_q));
endmodule

// File: rtl/sr_phase_balancer.sv
module sr_phase_balancer
  import sr_bal_pkg::*;
#(
  parameter int CUR_W   = 12,
  parameter int PER_W   = 16,
  parameter int VOUT_ON = 600,
  parameter int IOUT_ON = 140,
  parameter int IOUT_OFF = 100,
  parameter int MIN_T   = 400,
  parameter int OFF_T   = 496,
  parameter int RAMP_T  = 40,
  parameter int TRIM_T  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CUR_W-1:0] ia_i,
  input  logic [CUR_W-1:0] ib_i,
  input  logic [CUR_W-1:0] itot_i,
  input  logic [CUR_W-1:0] vout_i,
  input  logic [PER_W-1:0] half_per_i,
  output logic             sr_en_a_o,
  output logic             sr_en_b_o,
  output logic [PER_W-1:0] ton_a_o,
  output logic [PER_W-1:0] ton_b_o,
  output logic [1:0]       state_o
);
  localparam int NPH = 2;
  localparam logic [CUR_W-1:0] VON  = CUR_W'(VOUT_ON);
  localparam logic [CUR_W-1:0] ION  = CUR_W'(IOUT_ON);
  localparam logic [CUR_W-1:0] IOFF = CUR_W'(IOUT_OFF);

  bal_state_e       state_q, state_d;
  logic             fix_b_q, en_q;
  logic             drop, arm_ok;
  logic [CUR_W-1:0] i_adj, i_fix;
  logic [PER_W-1:0] ton_max;
  logic [PER_W-1:0] ton  [NPH];
  logic             full [NPH];
  trim_cmd_e        cmd  [NPH];
  trim_cmd_e        dir;

  sr_bal_limit #(.W(PER_W), .MIN_T(MIN_T), .OFF_T(OFF_T)) u_limit (
    .half_per_i (half_per_i),
    .max_o      (ton_max)
  );

  genvar p;
  generate
    for (p = 0; p < NPH; p++) begin : g_ph
      sr_bal_trim #(.W(PER_W), .MIN_T(MIN_T), .RAMP_T(RAMP_T), .TRIM_T(TRIM_T)) u_trim (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cmd_i       (cmd[p]),
        .max_i       (ton_max),
        .ton_o       (ton[p]),
        .ramp_full_o (full[p])
      );
    end
  endgenerate

  assign drop   = itot_i < IOFF;
  assign arm_ok = (vout_i > VON) && (itot_i > ION);
  // fix_b_q set: B fixed, A adjusted
  assign i_adj  = fix_b_q ? ia_i : ib_i;
  assign i_fix  = fix_b_q ? ib_i : ia_i;

  always_comb begin
    if (i_adj > i_fix)      dir = TC_DOWN;
    else if (i_adj < i_fix) dir = TC_UP;
    else                    dir = TC_HOLD;
  end

  always_comb begin
    for (int k = 0; k < NPH; k++) begin
      cmd[k] = TC_HOLD;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE, ST_ARM: cmd[k] = TC_MIN;
          ST_RAMP:         cmd[k] = drop ? TC_MIN : TC_RAMP;
          ST_RUN: begin
            if (drop)                           cmd[k] = TC_MIN;
            else if ((k == 0) == fix_b_q)       cmd[k] = dir;
            else                                cmd[k] = TC_HOLD;
          end
          default: cmd[k] = TC_HOLD;
        endcase
      end
    end
  end

  always_comb begin
    state_d = state_q;
    if (tick_i) begin
      unique case (state_q)
        ST_IDLE: if (arm_ok) state_d = ST_ARM;
        ST_ARM:  state_d = ST_RAMP;
        ST_RAMP: state_d = drop ? ST_IDLE : (full[0] ? ST_RUN : ST_RAMP);
        ST_RUN:  if (drop) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fix_b_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (tick_i) en_q <= (state_d == ST_RAMP) || (state_d == ST_RUN);
      if (tick_i && state_q == ST_ARM) fix_b_q <= ib_i < ia_i;
    end
  end

  assign sr_en_a_o = en_q;
  assign sr_en_b_o = en_q;
  assign ton_a_o   = ton[0];
  assign ton_b_o   = ton[1];
  assign state_o   = state_q;

  a_r9_dropout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (state_q == ST_RUN || state_q == ST_RAMP) && drop) |=>
      (state_q == ST_IDLE && !en_q && ton[0] == PER_W'(MIN_T)));

  a_r2_idle_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_ARM) |-> !en_q);

  a_r7_fixed_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q) == ST_RUN) |->
      (fix_b_q ? $stable(ton[1]) : $stable(ton[0])));

  a_r10_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(state_q) && $stable(en_q)));

  a_r5_ramp_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RAMP |-> ton[0] == ton[1]);
endmodule

// File: tb/sr_phase_balancer_test.sv
module sr_phase_balancer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [11:0] ia = '0, ib = '0, itot = '0, vout = '0;
  logic [15:0] hp = 16'd2000;
  logic        en_a, en_b;
  logic [15:0] ta, tb;
  logic [1:0]  st;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state
  int m_st = 0, m_fixb = 0, m_ta = 400, m_tb = 400, m_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_phase_balancer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .ia_i(ia), .ib_i(ib), .itot_i(itot), .vout_i(vout), .half_per_i(hp),
    .sr_en_a_o(en_a), .sr_en_b_o(en_b), .ton_a_o(ta), .ton_b_o(tb), .state_o(st)
  );

  function automatic int ceil_of(int h);
    return (h > 896) ? h - 496 : 400;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "state", int'(st), m_st);
    check(tag, "en_a", int'(en_a), m_en);
    check(tag, "en_b", int'(en_b), m_en);
    check(tag, "ton_a", int'(ta), m_ta);
    check(tag, "ton_b", int'(tb), m_tb);
  endtask

  // advance model by one tick, return requirement tag exercised
  function automatic string model_step();
    int mx, n, adj, fix, cur;
    string tag;
    mx = ceil_of(int'(hp));
    tag = "R2";
    case (m_st)
      0: begin
        m_ta = 400; m_tb = 400; m_en = 0;
        if (int'(vout) > 600 && int'(itot) > 140) m_st = 1;
        tag = "R2";
      end
      1: begin
        m_fixb = (ib < ia) ? 1 : 0;
        m_ta = 400; m_tb = 400; m_en = 1; m_st = 2;
        tag = "R4";
      end
      2: begin
        if (int'(itot) < 100) begin
          m_st = 0; m_en = 0; m_ta = 400; m_tb = 400; tag = "R9";
        end else begin
          n = m_ta + 40;
          if (n >= mx) begin m_ta = mx; m_tb = mx; m_st = 3; end
          else begin m_ta = n; m_tb = n; end
          tag = "R5";
        end
      end
      default: begin
        if (int'(itot) < 100) begin
          m_st = 0; m_en = 0; m_ta = 400; m_tb = 400; tag = "R9";
        end else begin
          adj = m_fixb ? int'(ia) : int'(ib);
          fix = m_fixb ? int'(ib) : int'(ia);
          cur = m_fixb ? m_ta : m_tb;
          tag = "R6";
          if (adj > fix) begin
            if (cur < 408) begin cur = 400; tag = "R8"; end else cur = cur - 8;
          end else if (adj < fix) begin
            if (cur + 8 > mx) begin cur = mx; tag = "R8"; end else cur = cur + 8;
          end else tag = "R7";
          if (m_fixb) m_ta = cur; else m_tb = cur;
        end
      end
    endcase
    return tag;
  endfunction

  task automatic do_tick(input int a, input int b, input int t, input int v);
    string tag;
    @(negedge clk);
    ia = 12'(a); ib = 12'(b); itot = 12'(t); vout = 12'(v);
    tick = 1'b1;
    tag = model_step();
    @(negedge clk);
    tick = 1'b0;
    check_all(tag);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ia = 12'($urandom_range(0, 400)); ib = 12'($urandom_range(0, 400));
      itot = 12'($urandom_range(0, 400)); vout = 12'($urandom_range(0, 900));
    end
    @(negedge clk);
    check_all("R10");
  endtask

  task automatic go_idle();
    do_tick(50, 50, 20, 700);
    if (m_st != 0) do_tick(50, 50, 20, 700);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2: thresholds strict
    do_tick(100, 100, 300, 600);
    do_tick(100, 100, 140, 700);
    do_tick(100, 100, 141, 601);
    check("R2", "armed", int'(st), 1);

    // R3: A smaller -> A fixed, B adjusted
    do_tick(100, 200, 300, 700);
    check("R4", "ramp entry ton", int'(ta), 400);
    while (m_st == 2) do_tick(100, 200, 300, 700);
    do_tick(100, 200, 300, 700);
    check("R3", "A fixed at ceiling", int'(ta), 1504);
    check("R3", "B trimmed down", int'(tb), 1496);
    do_tick(150, 150, 300, 700);
    check("R7", "equal holds", int'(tb), 1496);
    do_tick(200, 100, 300, 700);
    check("R6", "B trimmed up", int'(tb), 1504);
    do_tick(200, 100, 300, 700);
    check("R8", "ceiling clamp", int'(tb), 1504);
    idle_cycles(5);
    do_tick(100, 200, 99, 700);
    check("R9", "dropout", int'(st), 0);

    // B smaller -> B fixed
    do_tick(300, 100, 200, 700);
    do_tick(300, 100, 200, 700);
    while (m_st == 2) do_tick(300, 100, 200, 700);
    do_tick(300, 100, 200, 700);
    check("R3", "A trimmed down", int'(ta), 1496);
    check("R3", "B fixed", int'(tb), 1504);
    go_idle();

    // tie -> A fixed; dropout in ramp
    do_tick(0, 0, 200, 700);
    do_tick(120, 120, 200, 700);
    do_tick(120, 120, 200, 700);
    do_tick(120, 120, 99, 700);
    check("R9", "ramp dropout", int'(st), 0);
    do_tick(0, 0, 200, 700);
    do_tick(120, 120, 200, 700);
    while (m_st == 2) do_tick(120, 120, 200, 700);
    do_tick(120, 300, 200, 700);
    check("R3", "tie: B adjusted", int'(tb), 1496);
    go_idle();

    // ceiling floors at minimum; floor clamp on trim
    hp = 16'd800;
    do_tick(0, 0, 200, 700);
    do_tick(100, 200, 200, 700);
    do_tick(100, 200, 200, 700);
    check("R5", "ceiling floor", int'(st), 3);
    do_tick(100, 200, 200, 700);
    check("R8", "floor clamp", int'(tb), 400);
    go_idle();

    // random traffic
    for (int e = 0; e < 4000; e++) begin
      if (m_st == 0 && $urandom_range(0, 9) == 0)
        hp = 16'($urandom_range(700, 2600));
      do_tick($urandom_range(0, 300), $urandom_range(0, 300),
              ($urandom_range(0, 15) == 0) ? $urandom_range(0, 99) : $urandom_range(100, 400),
              $urandom_range(500, 700));
      if ($urandom_range(0, 99) == 0) idle_cycles(3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule